// File: doc/BRIEF.md
# Load/Store Byte-Lane Aligner

This block sits between a 32-bit register datapath and a memory that is one word wide. Each request carries a base register value, a signed 16-bit displacement and an operation. The block adds the two to get the effective address and drives the memory word address from it. It also drives the per-byte write enables and the write data that the memory merges under those enables. A word access whose address is not a multiple of four is refused and flagged.

The memory returns its read word one cycle after the request. The block keeps the byte lane and load kind of each accepted load for that one cycle. When the read word arrives, it picks out the addressed word or byte and sign- or zero-extends a byte into a 32-bit result. A parameter fixes how a byte address maps onto the bits of a word: big-endian puts byte 0 in the most significant lane, little-endian puts it in the least significant lane.

Top module: `lsu_align`

## Requirements
- R1: The effective address is `base` plus `offset` sign-extended to 32 bits, and `mem_addr` equals bits 31:2 of that sum in the same cycle as the request.
- R2: A word access (op 0 or 3) whose effective address has nonzero bits 1:0 raises `misalign`, drives `byte_en` to 0000, and produces no load result. An aligned word store drives `byte_en` 1111 with `wr_data` equal to `st_data`.
- R3: Byte k of a word (k = effective address bits 1:0) occupies bits [31-8k:24-8k] when BIG_ENDIAN=1, and bits [8k+7:8k] when BIG_ENDIAN=0.
- R4: A byte store (op 4) asserts only the `byte_en` bit of the addressed lane (bit i enables bits [8i+7:8i]) and carries `st_data[7:0]` in that lane. After the memory merges the write, the other three bytes of the word are unchanged.
- R5: An accepted load sets `ld_valid` in the cycle after the request, and `ld_data` is formed from `rd_word` in that cycle. A word load (op 0) returns `rd_word` unchanged.
- R6: A signed byte load (op 1) copies bit 7 of the selected byte into bits 31:8. An unsigned byte load (op 2) clears bits 31:8. Bits 7:0 hold the addressed byte.
- R7: Operation codes are 0 word load, 1 signed byte load, 2 unsigned byte load, 3 word store, 4 byte store. When `req_valid` is low, or when the code is 5 to 7, there are no write enables, no `misalign` and no load result.
- R8: While and after reset with no load pending, `ld_valid` is low and `ld_data` is zero.
- R9: With word 0x009012A0 at byte address 0 and 0xFFFFFFFF at address 4, an unsigned byte load from address 1 returns 0x00000090 (big-endian) or 0x00000012 (little-endian). Storing that byte to address 6 leaves address 4 holding 0xFFFF90FF or 0xFF12FFFF respectively.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Request present this cycle |
| op | input | 3 | Operation code (R7) |
| base | input | 32 | Base register value |
| offset | input | 16 | Signed displacement |
| st_data | input | 32 | Source register for stores |
| rd_word | input | 32 | Memory read word, one cycle after the request |
| mem_addr | output | 30 | Memory word address |
| byte_en | output | 4 | Per-byte write enables |
| wr_data | output | 32 | Write data, lane-placed |
| misalign | output | 1 | Misaligned word access refused |
| ld_valid | output | 1 | Load result valid |
| ld_data | output | 32 | Extended load result |

## Verification
The bench builds two copies side by side, one with BIG_ENDIAN=1 and one with BIG_ENDIAN=0. Each copy has its own word memory model that merges writes under the byte enables. Running both copies on the same requests lets every byte offset be compared against both lane numberings in one run. It also lets the same store-then-reload sequence show the two different merged words. Displacements span negative and positive values, so the sign extension of the address is exercised together with every lane.

// File: rtl/lsu_align.sv
module lsu_align #(
  parameter bit BIG_ENDIAN = 1'b1,
  parameter int OFF_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [2:0]        op,
  input  logic [31:0]       base,
  input  logic [OFF_W-1:0]  offset,
  input  logic [31:0]       st_data,
  input  logic [31:0]       rd_word,
  output logic [29:0]       mem_addr,
  output logic [3:0]        byte_en,
  output logic [31:0]       wr_data,
  output logic              misalign,
  output logic              ld_valid,
  output logic [31:0]       ld_data
);
  localparam logic [2:0] OP_LW = 3'd0, OP_LBS = 3'd1, OP_LBU = 3'd2,
                         OP_SW = 3'd3, OP_SB = 3'd4;

  logic [31:0] ea;
  logic [1:0]  lane;
  logic        is_word, is_load;
  logic        q_valid;
  logic [2:0]  q_op;
  logic [1:0]  q_lane;
  logic [7:0]  sel_byte;

  assign ea       = base + {{(32-OFF_W){offset[OFF_W-1]}}, offset};
  assign lane     = BIG_ENDIAN ? 2'd3 - ea[1:0] : ea[1:0];
  assign is_word  = (op == OP_LW) || (op == OP_SW);
  assign is_load  = (op == OP_LW) || (op == OP_LBS) || (op == OP_LBU);
  assign mem_addr = ea[31:2];
  assign misalign = req_valid && is_word && (ea[1:0] != 2'd0);

  always_comb begin
    byte_en = 4'b0000;
    if (req_valid && !misalign) begin
      if (op == OP_SW) byte_en = 4'b1111;
      else if (op == OP_SB) byte_en = 4'b0001 << lane;
    end
  end

  assign wr_data = (op == OP_SB) ? {4{st_data[7:0]}} : st_data;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q_valid <= 1'b0;
      q_op    <= OP_LW;
      q_lane  <= 2'd0;
    end else begin
      q_valid <= req_valid && is_load && !misalign;
      q_op    <= op;
      q_lane  <= lane;
    end
  end

  assign sel_byte = rd_word[{q_lane, 3'b000} +: 8];
  assign ld_valid = q_valid;

  always_comb begin
    ld_data = 32'd0;
    if (q_valid) begin
      case (q_op)
        OP_LW:   ld_data = rd_word;
        OP_LBS:  ld_data = {{24{sel_byte[7]}}, sel_byte};
        default: ld_data = {24'd0, sel_byte};
      endcase
    end
  end
endmodule

module lsu_align_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        req_valid,
  input logic [2:0]  op,
  input logic [3:0]  byte_en,
  input logic        misalign,
  input logic        ld_valid,
  input logic [31:0] ld_data
);
  a_r2_misalign_no_write: assert property (@(posedge clk) disable iff (!rst_n)
    misalign |-> (byte_en == 4'b0000));

  a_r2_misalign_no_load: assert property (@(posedge clk) disable iff (!rst_n)
    misalign |=> !ld_valid);

  a_r4_single_lane: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_en != 4'b1111) |-> $onehot0(byte_en));

  a_r5_load_follows_request: assert property (@(posedge clk) disable iff (!rst_n)
    ld_valid |-> $past(req_valid));

  a_r6_zero_extend: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_valid && $past(op) == 3'd2) |-> (ld_data[31:8] == 24'd0));

  a_r6_sign_extend: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_valid && $past(op) == 3'd1) |-> (ld_data[31:8] == {24{ld_data[7]}}));

  a_r7_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (!req_valid || op > 3'd4) |-> (byte_en == 4'b0000 && !misalign));

  a_r8_no_result_data: assert property (@(posedge clk) disable iff (!rst_n)
    !ld_valid |-> (ld_data == 32'd0));
endmodule

bind lsu_align lsu_align_chk u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .op(op),
  .byte_en(byte_en), .misalign(misalign), .ld_valid(ld_valid), .ld_data(ld_data)
);

// File: tb/sim_lsu_align.sv
module sim_lsu_align;
  localparam int CLK_P = 10;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 1'b0;
  logic [2:0] op = 3'd0;
  logic [31:0] base = 32'd0;
  logic [15:0] offset = 16'd0;
  logic [31:0] st_b = 32'd0, st_l = 32'd0;
  logic [31:0] rd_b, rd_l;
  logic [29:0] addr_b, addr_l;
  logic [3:0]  be_b, be_l;
  logic [31:0] wd_b, wd_l, ld_b, ld_l;
  logic        mis_b, mis_l, lv_b, lv_l;

  int errors = 0, checks = 0;
  bit done = 0;

  logic [31:0] mb [8];
  logic [31:0] ml [8];
  logic [2:0]  aq_b = 3'd0, aq_l = 3'd0;
  logic        pv = 1'b0;
  logic [2:0]  pop = 3'd0;
  logic [1:0]  pa = 2'd0;
  logic [31:0] ea_m;

  always #(CLK_P/2) clk = ~clk;

  lsu_align #(.BIG_ENDIAN(1'b1)) u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .op(op), .base(base),
    .offset(offset), .st_data(st_b), .rd_word(rd_b), .mem_addr(addr_b),
    .byte_en(be_b), .wr_data(wd_b), .misalign(mis_b), .ld_valid(lv_b), .ld_data(ld_b));

  lsu_align #(.BIG_ENDIAN(1'b0)) u1 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .op(op), .base(base),
    .offset(offset), .st_data(st_l), .rd_word(rd_l), .mem_addr(addr_l),
    .byte_en(be_l), .wr_data(wd_l), .misalign(mis_l), .ld_valid(lv_l), .ld_data(ld_l));

  assign ea_m = base + {{16{offset[15]}}, offset};
  assign rd_b = mb[aq_b];
  assign rd_l = ml[aq_l];

  // Memory model: byte-wise merge under enables
  always @(posedge clk) begin
    for (int i = 0; i < 4; i++) begin
      if (be_b[i]) mb[addr_b[2:0]][8*i +: 8] <= wd_b[8*i +: 8];
      if (be_l[i]) ml[addr_l[2:0]][8*i +: 8] <= wd_l[8*i +: 8];
    end
    aq_b <= addr_b[2:0];
    aq_l <= addr_l[2:0];
  end

  // Pending-load record of the reference model
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) pv <= 1'b0;
    else begin
      pv  <= req_valid && op <= 3'd2 && !(op == 3'd0 && ea_m[1:0] != 2'd0);
      pop <= op;
      pa  <= ea_m[1:0];
    end
  end

  task automatic cmp(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [7:0] byte_at(bit big, logic [31:0] w, logic [1:0] k);
    logic [7:0] b [4];
    for (int j = 0; j < 4; j++) b[j] = big ? w[31-8*j -: 8] : w[8*j +: 8];
    return b[k];
  endfunction

  task automatic check_unit(string nm, bit big, logic [29:0] addr, logic [3:0] be,
                            logic [31:0] wd, logic [31:0] st, logic mis, logic lv,
                            logic [31:0] ld, logic [31:0] rdw);
    logic word_op, exp_mis;
    logic [3:0] exp_be;
    logic [31:0] exp_ld;
    logic [7:0] bt;
    int ln;
    word_op = (op == 3'd0 || op == 3'd3);
    exp_mis = req_valid && word_op && ea_m[1:0] != 2'd0;
    ln = big ? 3 - ea_m[1:0] : ea_m[1:0];
    exp_be = 4'b0000;
    if (req_valid && !exp_mis && op == 3'd3) exp_be = 4'b1111;
    if (req_valid && op == 3'd4) exp_be[ln] = 1'b1;
    cmp({nm, " R1 mem_addr"}, {2'b00, addr}, {2'b00, ea_m[31:2]});
    cmp({nm, " R2/R7 misalign"}, {31'd0, mis}, {31'd0, exp_mis});
    cmp({nm, " R2/R4/R7 byte_en"}, {28'd0, be}, {28'd0, exp_be});
    if (exp_be == 4'b1111) cmp({nm, " R2 word wr_data"}, wd, st);
    if (req_valid && op == 3'd4)
      cmp({nm, " R3/R4 byte lane data"}, {24'd0, byte_at(big, wd, ea_m[1:0])}, {24'd0, st[7:0]});
    cmp({nm, " R5/R7/R8 ld_valid"}, {31'd0, lv}, {31'd0, pv});
    exp_ld = 32'd0;
    if (pv) begin
      bt = byte_at(big, rdw, pa);
      if (pop == 3'd0) exp_ld = rdw;
      else if (pop == 3'd1) exp_ld = {{24{bt[7]}}, bt};
      else exp_ld = {24'd0, bt};
    end
    cmp({nm, " R3/R5/R6 ld_data"}, ld, exp_ld);
  endtask

  task automatic step(bit v, logic [2:0] o, logic [31:0] b, logic [15:0] off,
                      logic [31:0] sb, logic [31:0] sl);
    @(negedge clk);
    req_valid = v; op = o; base = b; offset = off; st_b = sb; st_l = sl;
    #2;
    check_unit("BE", 1'b1, addr_b, be_b, wd_b, st_b, mis_b, lv_b, ld_b, rd_b);
    check_unit("LE", 1'b0, addr_l, be_l, wd_l, st_l, mis_l, lv_l, ld_l, rd_l);
  endtask

  initial begin
    for (int i = 0; i < 8; i++) begin mb[i] = 32'd0; ml[i] = 32'd0; end
    repeat (3) @(negedge clk);
    cmp("R8 reset ld_valid", {31'd0, lv_b | lv_l}, 32'd0);
    cmp("R8 reset ld_data", ld_b | ld_l, 32'd0);
    rst_n = 1'b1;
    step(0, 3'd3, 0, 0, 0, 0);
    // R9 memory set-up: word stores, second through a negative displacement
    step(1, 3'd3, 32'd0, 16'd0, 32'h009012A0, 32'h009012A0);
    step(1, 3'd3, 32'd8, 16'hFFFC, 32'hFFFFFFFF, 32'hFFFFFFFF);
    step(1, 3'd2, 32'd0, 16'd1, 0, 0);
    step(0, 3'd0, 0, 0, 0, 0);
    cmp("BE R9 unsigned byte load", ld_b, 32'h00000090);
    cmp("LE R9 unsigned byte load", ld_l, 32'h00000012);
    step(1, 3'd4, 32'd0, 16'd6, 32'hABCDEF90, 32'hABCDEF12);
    step(1, 3'd0, 32'd4, 16'd0, 0, 0);
    step(0, 3'd0, 0, 0, 0, 0);
    cmp("BE R9/R4 merged word", ld_b, 32'hFFFF90FF);
    cmp("LE R9/R4 merged word", ld_l, 32'hFF12FFFF);
    // R6 signed byte load of 0x90 / 0x12
    step(1, 3'd1, 32'd0, 16'd1, 0, 0);
    step(0, 3'd0, 0, 0, 0, 0);
    cmp("BE R6 signed byte", ld_b, 32'hFFFFFF90);
    cmp("LE R6 signed byte", ld_l, 32'h00000012);
    // R2 misaligned word store is refused; word unchanged afterwards
    step(1, 3'd3, 32'd0, 16'd2, 32'h12345678, 32'h12345678);
    step(1, 3'd0, 32'd0, 16'd0, 0, 0);
    step(0, 3'd0, 0, 0, 0, 0);
    cmp("BE R2 word kept", ld_b, 32'h009012A0);
    cmp("LE R2 word kept", ld_l, 32'h009012A0);
    step(1, 3'd0, 32'd3, 16'd0, 0, 0);
    step(0, 3'd0, 0, 0, 0, 0);
    cmp("R2 misaligned load no result", {31'd0, lv_b | lv_l}, 32'd0);
    // R7 undefined codes and idle store
    step(1, 3'd5, 32'd0, 16'd0, 32'hFFFFFFFF, 32'hFFFFFFFF);
    step(1, 3'd7, 32'd4, 16'd0, 32'hFFFFFFFF, 32'hFFFFFFFF);
    step(0, 3'd3, 32'd0, 16'd0, 32'h0, 32'h0);
    step(1, 3'd0, 32'd0, 16'd0, 0, 0);
    step(0, 3'd0, 0, 0, 0, 0);
    cmp("BE R7 no write by ignored ops", ld_b, 32'h009012A0);
    cmp("LE R7 no write by ignored ops", ld_l, 32'h009012A0);
    // Mixed traffic across every lane and displacement sign
    for (int n = 0; n < 400; n++) begin
      logic [31:0] s;
      s = $urandom;
      step(($urandom % 4) != 0, 3'($urandom % 8), 32'($urandom % 64),
           16'(int'($urandom % 16) - 8), s, ~s);
    end
    step(0, 3'd0, 0, 0, 0, 0);
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        #(CLK_P * 20000);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=timeout expected=completion");
      end
    join_any
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule